// File: doc/BRIEF.md
# Multi-line shared receive silo

This block gathers characters from up to eight serial receivers into a single shared queue of 64 entries. Each receiver presents a finished character as a one-cycle strobe together with its framing and parity error flags. Every line has a one-character holding register. A fixed-priority scanner moves one held character per cycle into the queue. Each queued entry records the character, the number of the line it came from, and its error flags.

The host pops the queue one 16-bit word at a time. The word at the head is always visible on `rd_data_o`, and pulsing `rd_i` removes it. The host keeps reading while the valid bit is set. There are two interrupt modes. In per-character mode the request is raised while anything is queued. In alarm mode the request is raised only once 16 characters have been accepted since the host's last read. Bit-level deserialisation and baud generation take place upstream of this block.

Top module: `rx_silo`

## Requirements
- R1: After reset the queue is empty, `rd_data_o` is 16'h0000 and `irq_o` is low.
- R2: Entries leave in the order they were accepted. A word has the character in bits 7:0, the line number in bits 10:8 and a set valid flag in bit 15. Bit 11 is always zero.
- R3: The parity-error flag of the character appears in bit 12 and the framing-error flag in bit 13. A break (framing error with character 8'h00) is stored as an ordinary entry with bit 13 set and a zero character.
- R4: Reading an empty queue returns 16'h0000 and has no effect on the queue.
- R5: The queue holds 64 entries. A character that reaches a full queue, in a cycle with no read, is dropped. The next accepted entry carries the overrun flag in bit 14. Entries after that one have bit 14 clear again.
- R6: When several lines strobe in the same cycle, every character is kept. They enter the queue lowest line number first, one per cycle.
- R7: A strobe on a line whose held character has not yet moved replaces that character. The replacing entry carries the overrun flag in bit 14.
- R8: While `scan_en_i` is low, strobes are ignored, held characters are discarded and nothing enters the queue. Characters already queued are kept.
- R9: With `rx_ie_i` high and `alarm_en_i` low, `irq_o` is high exactly while the queue is not empty.
- R10: With `rx_ie_i` and `alarm_en_i` high, `irq_o` rises once 16 entries have been accepted since the last read. It falls in the cycle after a read.
- R11: With `rx_ie_i` low, `irq_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_en_i | input | 1 | Master scan enable; characters are accepted only while high |
| rx_ie_i | input | 1 | Receive interrupt enable |
| alarm_en_i | input | 1 | Selects the 16-entry alarm interrupt mode |
| rx_stb_i | input | 8 | Per-line character strobe, one cycle |
| rx_char_i | input | 64 | Per-line character, line n in bits 8n+7:8n |
| rx_fe_i | input | 8 | Per-line framing-error flag |
| rx_pe_i | input | 8 | Per-line parity-error flag |
| rd_i | input | 1 | Pop the head entry |
| rd_data_o | output | 16 | Head entry word, or zero when empty |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The assertions assume that `rd_i` is a clean single-bit pulse. They also assume that the mode inputs change only between characters, never in the cycle a character is being scanned. In the bench every input changes on the falling edge. The enables and the mode are changed only while the holding registers are idle. Reads are never issued in the same cycle as a strobe when alarm timing or overflow is being measured.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;
  localparam int LINE_FW = 3;

  typedef struct packed {
    logic               ovr;
    logic               fe;
    logic               pe;
    logic [LINE_FW-1:0] line;
    logic [7:0]         ch;
  } silo_ent_t;

  function automatic logic [15:0] pack_word(logic vld, silo_ent_t e);
    return vld ? {1'b1, e.ovr, e.fe, e.pe, 1'b0, e.line, e.ch} : 16'h0000;
  endfunction
endpackage

// File: rtl/rx_line_hold.sv
module rx_line_hold
  import rx_silo_pkg::*;
#(
  parameter int LINE_ID = 0
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      scan_en_i,
  input  logic      stb_i,
  input  logic [7:0] ch_i,
  input  logic      fe_i,
  input  logic      pe_i,
  input  logic      grant_i,
  output logic      vld_o,
  output silo_ent_t ent_o
);
  logic      vld_q;
  silo_ent_t ent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      ent_q <= '0;
    end else if (!scan_en_i) begin
      vld_q <= 1'b0;
    end else if (stb_i) begin
      vld_q      <= 1'b1;
      ent_q.ch   <= ch_i;
      ent_q.fe   <= fe_i;
      ent_q.pe   <= pe_i;
      ent_q.line <= LINE_FW'(LINE_ID);
      ent_q.ovr  <= vld_q && !grant_i;  // unsent char overwritten
    end else if (grant_i) begin
      vld_q <= 1'b0;
    end
  end

  assign vld_o = vld_q;
  assign ent_o = ent_q;
endmodule

// File: rtl/rx_scan_arb.sv
module rx_scan_arb #(
  parameter int N   = 8,
  parameter int IDW = 3
) (
  input  logic [N-1:0]   req_i,
  input  logic           en_i,
  output logic [N-1:0]   gnt_o,
  output logic [IDW-1:0] idx_o,
  output logic           any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i] && en_i) begin
        gnt_o = '0;
        gnt_o[i] = 1'b1;
        idx_o = IDW'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_silo_fifo.sv
module rx_silo_fifo
  import rx_silo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      push_i,
  input  silo_ent_t push_ent_i,
  input  logic      pop_i,
  output silo_ent_t head_o,
  output logic      empty_o,
  output logic      full_o,
  output logic [CW-1:0] cnt_o
);
  silo_ent_t       mem [DEPTH];
  logic [AW-1:0]   wp_q, rp_q;
  logic [CW-1:0]   cnt_q;
  logic            do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem[rp_q];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wp_q] <= push_ent_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= wp_q + 1'b1;
      if (do_pop) rp_q <= rp_q + 1'b1;
      case ({push_i, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/rx_silo.sv
module rx_silo
  import rx_silo_pkg::*;
#(
  parameter int NLINES    = 8,
  parameter int DEPTH     = 64,
  parameter int ALARM_LVL = 16,
  localparam int LINE_W = (NLINES > 1) ? $clog2(NLINES) : 1,
  localparam int CW     = $clog2(DEPTH) + 1,
  localparam int AC_W   = $clog2(ALARM_LVL + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                scan_en_i,
  input  logic                rx_ie_i,
  input  logic                alarm_en_i,
  input  logic [NLINES-1:0]   rx_stb_i,
  input  logic [NLINES*8-1:0] rx_char_i,
  input  logic [NLINES-1:0]   rx_fe_i,
  input  logic [NLINES-1:0]   rx_pe_i,
  input  logic                rd_i,
  output logic [15:0]         rd_data_o,
  output logic                irq_o
);
  logic [NLINES-1:0] hold_vld, gnt;
  silo_ent_t         hold_ent [NLINES];
  logic [LINE_W-1:0] sel_idx;
  logic              sel_any;
  silo_ent_t         sel_ent, head_ent;
  logic              fifo_empty, fifo_full, push_ok, drop;
  logic [CW-1:0]     fifo_cnt;
  logic              ovr_pend_q;
  logic [AC_W-1:0]   alarm_cnt_q;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    rx_line_hold #(.LINE_ID(g)) u_hold (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .scan_en_i(scan_en_i),
      .stb_i    (rx_stb_i[g]),
      .ch_i     (rx_char_i[g*8 +: 8]),
      .fe_i     (rx_fe_i[g]),
      .pe_i     (rx_pe_i[g]),
      .grant_i  (gnt[g]),
      .vld_o    (hold_vld[g]),
      .ent_o    (hold_ent[g])
    );
  end

  rx_scan_arb #(.N(NLINES), .IDW(LINE_W)) u_arb (
    .req_i(hold_vld),
    .en_i (scan_en_i),
    .gnt_o(gnt),
    .idx_o(sel_idx),
    .any_o(sel_any)
  );

  always_comb begin
    sel_ent     = hold_ent[sel_idx];
    sel_ent.ovr = hold_ent[sel_idx].ovr | ovr_pend_q;
  end

  assign push_ok = sel_any && (!fifo_full || rd_i);
  assign drop    = sel_any && fifo_full && !rd_i;

  rx_silo_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (push_ok),
    .push_ent_i(sel_ent),
    .pop_i     (rd_i),
    .head_o    (head_ent),
    .empty_o   (fifo_empty),
    .full_o    (fifo_full),
    .cnt_o     (fifo_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_pend_q  <= 1'b0;
      alarm_cnt_q <= '0;
    end else begin
      if (drop)         ovr_pend_q <= 1'b1;
      else if (push_ok) ovr_pend_q <= 1'b0;
      if (rd_i)
        alarm_cnt_q <= '0;
      else if (push_ok && alarm_cnt_q != AC_W'(ALARM_LVL))
        alarm_cnt_q <= alarm_cnt_q + 1'b1;
    end
  end

  assign rd_data_o = pack_word(!fifo_empty, head_ent);
  assign irq_o = rx_ie_i && (alarm_en_i ? (alarm_cnt_q == AC_W'(ALARM_LVL))
                                        : !fifo_empty);
endmodule

// File: rtl/rx_silo_chk.sv
module rx_silo_chk #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scan_en_i,
  input logic          rx_ie_i,
  input logic          alarm_en_i,
  input logic          rd_i,
  input logic [15:0]   rd_data_o,
  input logic          irq_o,
  input logic [CW-1:0] fifo_cnt
);
  p_empty_word_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[15] |-> rd_data_o == 16'h0000);

  p_valid_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[15] == (fifo_cnt != '0));

  p_cap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CW'(DEPTH));

  p_scan_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_en_i |=> fifo_cnt <= $past(fifo_cnt));

  p_perchar_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ie_i && !alarm_en_i) |-> irq_o == rd_data_o[15]);

  p_alarm_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && alarm_en_i) |=> (!alarm_en_i || !irq_o));

  p_irq_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_ie_i |-> !irq_o);
endmodule

bind rx_silo rx_silo_chk #(.DEPTH(DEPTH)) i_rx_silo_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scan_en_i (scan_en_i),
  .rx_ie_i   (rx_ie_i),
  .alarm_en_i(alarm_en_i),
  .rd_i      (rd_i),
  .rd_data_o (rd_data_o),
  .irq_o     (irq_o),
  .fifo_cnt  (fifo_cnt)
);

// File: tb/test_rx_silo.sv
module test_rx_silo;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        scan_en = 1'b0, rx_ie = 1'b0, alarm_en = 1'b0, rd = 1'b0;
  logic [7:0]  stb = '0, fe = '0, pe = '0;
  logic [63:0] chars = '0;
  logic [15:0] rdata;
  logic        irq;
  int          n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  rx_silo i_rx_silo (
    .clk_i(clk), .rst_ni(rst_ni), .scan_en_i(scan_en), .rx_ie_i(rx_ie),
    .alarm_en_i(alarm_en), .rx_stb_i(stb), .rx_char_i(chars), .rx_fe_i(fe),
    .rx_pe_i(pe), .rd_i(rd), .rd_data_o(rdata), .irq_o(irq)
  );

  function automatic logic [15:0] ew(int ln, int c, bit f, bit p, bit o);
    return {1'b1, o, f, p, 1'b0, 3'(ln), 8'(c)};
  endfunction

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(int ln, int c, bit f, bit p);
    stb[ln] = 1'b1; chars[ln*8 +: 8] = 8'(c); fe[ln] = f; pe[ln] = p;
    @(negedge clk);
    stb = '0; fe = '0; pe = '0;
  endtask

  task automatic rd_chk(string req, logic [15:0] exp);
    chk(req, rdata, exp);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 80 && rdata[15]; k++) begin
      rd = 1'b1; @(negedge clk); rd = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    idle(3);
    chk("R1 reset word", rdata, 16'h0000);
    chk("R1 reset irq", {15'b0, irq}, 16'h0);
    rst_ni = 1'b1;
    idle(2);
    chk("R1 word after release", rdata, 16'h0000);
    scan_en = 1'b1;

    // R2/R3: sweep every line with every error-flag pattern
    for (int l = 0; l < 8; l++) send(l, l * 17 + 3, l[1], l[0]);
    idle(2);
    for (int l = 0; l < 8; l++)
      rd_chk("R2 R3 sweep order/tag/flags", ew(l, l * 17 + 3, l[1], l[0], 0));

    // R4: empty reads
    rd_chk("R4 empty read", 16'h0000);
    rd_chk("R4 empty read again", 16'h0000);

    // R3: break
    send(5, 0, 1, 0);
    idle(2);
    rd_chk("R3 break", 16'hA500);

    // R6: all lines at once, reverse data pattern
    for (int l = 0; l < 8; l++) begin
      stb[l] = 1'b1; chars[l*8 +: 8] = 8'(8'hF0 - l); pe[l] = (l % 3 == 0);
    end
    @(negedge clk);
    stb = '0; pe = '0;
    idle(10);
    for (int l = 0; l < 8; l++)
      rd_chk("R6 simultaneous priority", ew(l, 8'hF0 - l, 0, (l % 3 == 0), 0));
    rd_chk("R6 nothing extra", 16'h0000);

    // R7: line 1 overwritten before its turn
    stb[0] = 1'b1; stb[1] = 1'b1; chars[7:0] = 8'h11; chars[15:8] = 8'h22;
    @(negedge clk);
    stb[0] = 1'b0; chars[15:8] = 8'h33;
    @(negedge clk);
    stb = '0;
    idle(4);
    rd_chk("R7 first line kept", ew(0, 8'h11, 0, 0, 0));
    rd_chk("R7 replacement flagged", ew(1, 8'h33, 0, 0, 1));
    rd_chk("R7 old char gone", 16'h0000);

    // R8: scan disabled
    scan_en = 1'b0;
    send(3, 8'h44, 0, 0);
    idle(3);
    chk("R8 strobe ignored", rdata, 16'h0000);
    scan_en = 1'b1;
    stb[4] = 1'b1; stb[6] = 1'b1;
    @(negedge clk);
    stb = '0; scan_en = 1'b0;
    @(negedge clk);
    scan_en = 1'b1;
    idle(3);
    chk("R8 held chars discarded", rdata, ew(4, 8'hF0 - 4, 0, 0, 0) & 16'h0000);
    send(2, 8'h66, 0, 0);
    idle(2);
    scan_en = 1'b0;
    idle(2);
    chk("R8 queued entry kept", rdata, ew(2, 8'h66, 0, 0, 0));
    scan_en = 1'b1;
    drain();

    // R9: per-character interrupt
    rx_ie = 1'b1;
    idle(1);
    chk("R9 idle irq low", {15'b0, irq}, 16'h0);
    send(7, 8'h77, 0, 0);
    idle(2);
    chk("R9 irq with entry", {15'b0, irq}, 16'h1);
    rd_chk("R9 data", ew(7, 8'h77, 0, 0, 0));
    chk("R9 irq after drain", {15'b0, irq}, 16'h0);

    // R10: alarm threshold
    alarm_en = 1'b1;
    for (int i = 0; i < 15; i++) send(i % 8, 8'h80 + i, 0, 0);
    idle(2);
    chk("R10 15 entries no irq", {15'b0, irq}, 16'h0);
    send(3, 8'h8F, 0, 0);
    idle(2);
    chk("R10 16 entries irq", {15'b0, irq}, 16'h1);
    rd_chk("R10 head", ew(0, 8'h80, 0, 0, 0));
    chk("R10 irq drops after read", {15'b0, irq}, 16'h0);
    rx_ie = 1'b0;
    alarm_en = 1'b0;
    idle(1);
    chk("R11 irq masked with entries", {15'b0, irq}, 16'h0);
    rx_ie = 1'b1;
    idle(1);
    chk("R9 irq back in per-char mode", {15'b0, irq}, 16'h1);
    drain();
    rx_ie = 1'b0;

    // R5: fill, overflow, overrun tag
    for (int i = 0; i < 64; i++) send(i % 8, i, 0, 0);
    for (int i = 0; i < 3; i++) send(i, 8'hEE, 0, 0);
    idle(3);
    for (int i = 0; i < 64; i++) rd_chk("R5 full queue content", ew(i % 8, i, 0, 0, 0));
    rd_chk("R5 drops not stored", 16'h0000);
    send(2, 8'h55, 0, 1);
    idle(2);
    send(6, 8'h56, 0, 0);
    idle(2);
    rd_chk("R5 overrun on next entry", ew(2, 8'h55, 0, 1, 1));
    rd_chk("R5 overrun cleared after", ew(6, 8'h56, 0, 0, 0));

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule